// File: doc/BRIEF.md
# Read Delay Training Sweep

This block searches for a working pair of read-capture delays for a memory read path: a clock-delay code and a strobe-delay code. It relies on an outside training probe that, given the delay codes currently on its inputs, runs a trial read and answers pass or fail. The block owns the search only. It drives the candidate codes, waits for them to settle, requests a probe, and records the answer.

The search has two passes. The first pass tries every clock-delay code against every strobe-delay code and counts the passes for each clock code. The block then picks a centred clock code from the best-scoring window. The second pass sweeps the strobe codes again at that clock code and picks a centred strobe code. One confirming probe then decides the result. If either pass finds nothing, all codes fall back to zero and one probe at zero sets the status.

Every state of the controller is named:

- `ST_IDLE`: waits for `start`.
- `ST_SETTLE`: holds the codes for the settling time.
- `ST_PROBE`: keeps the request high until the answer arrives.
- `ST_RECORD`: books the answer and picks the next code or phase.
- `ST_SEARCH`: steps the target pass count down from the highest value.
- `ST_PICK_CLK`: chooses the centred clock code.
- `ST_PICK_DQS`: chooses the centred strobe code, or the zero fallback.
- `ST_DONE`: holds the result until the next `start`.

The transitions are:

- IDLE→SETTLE and DONE→SETTLE on `start`.
- SETTLE→PROBE when the settle time expires.
- PROBE→RECORD on `probe_done`.
- RECORD→SETTLE when more probes remain in the phase.
- RECORD→SEARCH after the last first-pass probe.
- RECORD→PICK_DQS after the last strobe probe.
- RECORD→DONE after the confirming or zero probe.
- SEARCH→PICK_CLK when some clock index holds the target count.
- SEARCH→SETTLE (zero fallback) when the target would fall below one.
- PICK_CLK→SETTLE.
- PICK_DQS→SETTLE.

Top module: `read_delay_trainer`

## Requirements
- R1: After reset `probe_req`, `train_done` and `train_ok` are 0, and both code outputs are all zero.
- R2: The first pass makes 105 probes, in this order: clock index 0..14 in the outer loop and strobe index 0..6 in the inner loop. Lane k of `dqs_dly_code` sits at bits [4k+3:4k], and all lanes carry the same strobe code. The clock table is 07,06,05,04,03,02,01,00,08,10,18,20,28,30,38 (hex). The strobe table is 3,2,1,0,E,D,C (hex).
- R3: Between a change of the codes and the rise of `probe_req`, the codes stay unchanged for at least SETTLE_CYC cycles. They also stay unchanged while `probe_req` is high.
- R4: `probe_req` stays high until a cycle with `probe_done` high. `probe_fail` in that cycle is the probe's answer (1 = fail).
- R5: The search takes the highest pass count held by any clock index, starting from 7 and going down. It finds the lowest and highest clock indices that hold exactly that count.
- R6: The centre is c=(lo+hi)>>1. If hi=N-1 and lo>0, c becomes (N+c)>>1. If hi<N-1 and lo=0, c becomes c>>1. N is 15 for clock indices and 7 for strobe indices.
- R7: If the clock index chosen by R6 holds fewer passes than the target count, lo is used instead.
- R8: At the chosen clock code, the 7 strobe codes are probed again and each one's pass flag is kept. The strobe code is chosen by R6 over the passing flags. If the chosen code did not pass, the lowest passing index is used. The chosen pair is then applied and probed once more, and `train_ok` equals the inverse of that probe's fail.
- R9: If no clock index has a count above zero, both codes go to zero and one probe follows (106 probes in total). `train_ok` is the inverse of its fail.
- R10: If no strobe code passes in the second pass, both codes go to zero and one probe follows (113 probes in total). `train_ok` is the inverse of its fail.
- R11: `train_done` stays high with the result and codes held until the next `start`. `start` is ignored while training runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training (accepted in idle or done) |
| probe_done | input | 1 | Probe answer valid |
| probe_fail | input | 1 | Probe result, 1 = fail |
| probe_req | output | 1 | Probe request |
| clk_dly_code | output | 6 | Candidate or chosen clock-delay code |
| dqs_dly_code | output | LANES*4 | Strobe-delay code, copied to every lane |
| train_ok | output | 1 | Final probe passed |
| train_done | output | 1 | Training finished |

## Verification
The hardest case to reach is the empty second pass. A probe whose answer depends only on the codes can never fail the whole strobe re-sweep at a clock index that scored above zero in the first pass. The bench's probe model therefore counts requests, and in one scenario it fails every probe after the 105th unless the codes are zero. That drives the R10 fallback, where the zero probe then passes. Other scenarios shape pass maps so that:

- the best window touches the top edge or the bottom edge of a table;
- the window is split, so the centre lands on a weaker index and R7 applies;
- nothing passes at all;
- only the confirming probe fails.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    localparam int CLK_N  = 15;
    localparam int DQS_N  = 7;
    localparam int CLK_CW = 6;
    localparam int DQS_CW = 4;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_PROBE,
        ST_RECORD,
        ST_SEARCH,
        ST_PICK_CLK,
        ST_PICK_DQS,
        ST_DONE
    } st_e;

    typedef enum logic [1:0] {
        PH_SWEEP,
        PH_STROBE,
        PH_CONFIRM,
        PH_ZERO
    } ph_e;

    // clock table: descending 7..0, then multiples of 8 up to 56
    function automatic logic [CLK_CW-1:0] clk_code(input logic [IDX_W-1:0] i);
        if (i < 4'd8)
            return CLK_CW'(4'd7 - i);
        return CLK_CW'(i - 4'd7) << 3;
    endfunction

    // strobe table: 3..0, then E..C
    function automatic logic [DQS_CW-1:0] dqs_code(input logic [IDX_W-1:0] i);
        if (i < 4'd4)
            return DQS_CW'(4'd3 - i);
        return DQS_CW'(5'd18 - {1'b0, i});
    endfunction

    // window centre with bias toward an edge the window touches
    function automatic logic [IDX_W-1:0] centre(input logic [IDX_W-1:0] lo,
                                                input logic [IDX_W-1:0] hi,
                                                input logic [IDX_W-1:0] n);
        logic [IDX_W:0] mid;
        mid = ({1'b0, lo} + {1'b0, hi}) >> 1;
        if (hi == n - 4'd1 && lo != 4'd0)
            mid = ({1'b0, n} + mid) >> 1;
        else if (hi < n - 4'd1 && lo == 4'd0)
            mid = mid >> 1;
        return mid[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/rdt_settle.sv
module rdt_settle #(
    parameter int CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || expired)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CW'(CYC - 1));

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(cnt_q) < CYC)); // R3

endmodule

// File: rtl/rdt_count_bank.sv
module rdt_count_bank #(
    parameter int N     = 15,
    parameter int IW    = 4,
    parameter int CW    = 3,
    parameter int LIMIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [IW-1:0] idx,
    output logic [N*CW-1:0] counts
);
    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [CW-1:0] c_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                c_q <= '0;
            else if (clr)
                c_q <= '0;
            else if (inc && idx == IW'(g))
                c_q <= c_q + 1'b1;
        end
        assign counts[g*CW +: CW] = c_q;

        AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && !clr && idx == IW'(g)) |-> (int'(c_q) < LIMIT)); // R5
    end

endmodule

// File: rtl/rdt_window.sv
module rdt_window #(
    parameter int N  = 15,
    parameter int IW = 4
) (
    input  logic [N-1:0]  hit,
    output logic          any,
    output logic [IW-1:0] lo,
    output logic [IW-1:0] hi
);
    always_comb begin
        any = |hit;
        lo  = '0;
        hi  = '0;
        for (int i = N - 1; i >= 0; i--)
            if (hit[i]) lo = IW'(i);
        for (int i = 0; i < N; i++)
            if (hit[i]) hi = IW'(i);
    end

endmodule

// File: rtl/read_delay_trainer.sv
module read_delay_trainer
    import rdt_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int SETTLE_CYC = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    probe_done,
    input  logic                    probe_fail,
    output logic                    probe_req,
    output logic [CLK_CW-1:0]       clk_dly_code,
    output logic [LANES*DQS_CW-1:0] dqs_dly_code,
    output logic                    train_ok,
    output logic                    train_done
);
    localparam int CNT_W    = $clog2(DQS_N + 1);
    localparam int SWEEP_PR = CLK_N * DQS_N;
    localparam int N_SHORT  = SWEEP_PR + 1;
    localparam int N_FULL   = SWEEP_PR + DQS_N + 1;
    localparam int STAB_W   = $clog2(SETTLE_CYC + 4);
    localparam int PCNT_W   = $clog2(N_FULL + 2);

    st_e  state_q, state_d;
    ph_e  phase_q;

    logic [IDX_W-1:0]       clk_idx_q;
    logic [IDX_W-1:0]       dqs_idx_q;
    logic [CNT_W-1:0]       target_q;
    logic [DQS_N-1:0]       flags_q;
    logic                   zero_q;
    logic                   ok_q;
    logic                   fail_q;

    logic                   expired;
    logic [CLK_N*CNT_W-1:0] counts;
    logic [CLK_N-1:0]       hit_a;
    logic                   any_a, any_b;
    logic [IDX_W-1:0]       lo_a, hi_a, lo_b, hi_b;
    logic [IDX_W-1:0]       clk_pick, dqs_pick;
    logic                   go;
    logic                   last_dqs, last_clk;

    assign go       = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign last_dqs = (dqs_idx_q == IDX_W'(DQS_N - 1));
    assign last_clk = (clk_idx_q == IDX_W'(CLK_N - 1));

    // ---------------- sub-blocks ----------------
    rdt_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_SETTLE),
        .expired (expired)
    );

    rdt_count_bank #(.N(CLK_N), .IW(IDX_W), .CW(CNT_W), .LIMIT(DQS_N)) u_counts (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (go),
        .inc    (state_q == ST_RECORD && phase_q == PH_SWEEP && !fail_q),
        .idx    (clk_idx_q),
        .counts (counts)
    );

    for (genvar g = 0; g < CLK_N; g++) begin : g_hit
        assign hit_a[g] = (counts[g*CNT_W +: CNT_W] == target_q);
    end

    rdt_window #(.N(CLK_N), .IW(IDX_W)) u_win_clk (
        .hit (hit_a),
        .any (any_a),
        .lo  (lo_a),
        .hi  (hi_a)
    );

    rdt_window #(.N(DQS_N), .IW(IDX_W)) u_win_dqs (
        .hit (flags_q),
        .any (any_b),
        .lo  (lo_b),
        .hi  (hi_b)
    );

    // ---------------- centre choice ----------------
    always_comb begin
        clk_pick = centre(lo_a, hi_a, IDX_W'(CLK_N));
        if (counts[int'(clk_pick)*CNT_W +: CNT_W] < target_q)
            clk_pick = lo_a;
    end

    always_comb begin
        dqs_pick = centre(lo_b, hi_b, IDX_W'(DQS_N));
        if (!flags_q[dqs_pick[2:0]])
            dqs_pick = lo_b;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_SETTLE;
            ST_SETTLE:   if (expired) state_d = ST_PROBE;
            ST_PROBE:    if (probe_done) state_d = ST_RECORD;
            ST_RECORD: begin
                unique case (phase_q)
                    PH_SWEEP:   state_d = (last_dqs && last_clk) ? ST_SEARCH : ST_SETTLE;
                    PH_STROBE:  state_d = last_dqs ? ST_PICK_DQS : ST_SETTLE;
                    PH_CONFIRM,
                    PH_ZERO:    state_d = ST_DONE;
                endcase
            end
            ST_SEARCH: begin
                if (any_a)
                    state_d = ST_PICK_CLK;
                else if (target_q == CNT_W'(1))
                    state_d = ST_SETTLE;
            end
            ST_PICK_CLK: state_d = ST_SETTLE;
            ST_PICK_DQS: state_d = ST_SETTLE;
            ST_DONE:     if (start) state_d = ST_SETTLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= PH_SWEEP;
            clk_idx_q <= '0;
            dqs_idx_q <= '0;
            target_q  <= '0;
            flags_q   <= '0;
            zero_q    <= 1'b1;
            ok_q      <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        phase_q   <= PH_SWEEP;
                        clk_idx_q <= '0;
                        dqs_idx_q <= '0;
                        zero_q    <= 1'b0;
                        ok_q      <= 1'b0;
                        flags_q   <= '0;
                    end
                end
                ST_SETTLE: ;
                ST_PROBE: begin
                    if (probe_done)
                        fail_q <= probe_fail;
                end
                ST_RECORD: begin
                    unique case (phase_q)
                        PH_SWEEP: begin
                            if (last_dqs) begin
                                dqs_idx_q <= '0;
                                if (last_clk)
                                    target_q <= CNT_W'(DQS_N);
                                else
                                    clk_idx_q <= clk_idx_q + 1'b1;
                            end else begin
                                dqs_idx_q <= dqs_idx_q + 1'b1;
                            end
                        end
                        PH_STROBE: begin
                            flags_q[dqs_idx_q[2:0]] <= !fail_q;
                            if (!last_dqs)
                                dqs_idx_q <= dqs_idx_q + 1'b1;
                        end
                        PH_CONFIRM,
                        PH_ZERO: ok_q <= !fail_q;
                    endcase
                end
                ST_SEARCH: begin
                    if (!any_a) begin
                        if (target_q == CNT_W'(1)) begin
                            zero_q  <= 1'b1;
                            phase_q <= PH_ZERO;
                        end else begin
                            target_q <= target_q - 1'b1;
                        end
                    end
                end
                ST_PICK_CLK: begin
                    clk_idx_q <= clk_pick;
                    dqs_idx_q <= '0;
                    flags_q   <= '0;
                    phase_q   <= PH_STROBE;
                end
                ST_PICK_DQS: begin
                    if (any_b) begin
                        dqs_idx_q <= dqs_pick;
                        phase_q   <= PH_CONFIRM;
                    end else begin
                        zero_q  <= 1'b1;
                        phase_q <= PH_ZERO;
                    end
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        probe_req    = (state_q == ST_PROBE);
        train_done   = (state_q == ST_DONE);
        train_ok     = ok_q;
        clk_dly_code = zero_q ? '0 : clk_code(clk_idx_q);
        dqs_dly_code = zero_q ? '0 : {LANES{dqs_code(dqs_idx_q)}};
    end

    // ---------------- checking support ----------------
    logic [CLK_CW+LANES*DQS_CW-1:0] codes_d;
    logic [STAB_W-1:0]              stab_q;
    logic [PCNT_W-1:0]              pcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            codes_d <= '0;
            stab_q  <= '0;
            pcnt_q  <= '0;
        end else begin
            codes_d <= {clk_dly_code, dqs_dly_code};
            if ({clk_dly_code, dqs_dly_code} != codes_d)
                stab_q <= '0;
            else if (stab_q != '1)
                stab_q <= stab_q + 1'b1;
            if (go)
                pcnt_q <= '0;
            else if (state_q == ST_SETTLE && expired)
                pcnt_q <= pcnt_q + 1'b1;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && !probe_done) |=> probe_req); // R4

    AST_CODES_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        probe_req |=> (!probe_req || $stable({clk_dly_code, dqs_dly_code}))); // R3

    AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_req) |-> (int'(stab_q) + 2 >= SETTLE_CYC)); // R3

    AST_PROBE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_done) |-> (int'(pcnt_q) == N_SHORT || int'(pcnt_q) == N_FULL)); // R2

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (train_done && !start) |=> (train_done && $stable(train_ok))); // R11

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        train_done |-> !probe_req); // R11

endmodule

// File: tb/read_delay_trainer_bench.sv
module read_delay_trainer_bench;

    localparam int LANES  = 4;
    localparam int SETTLE = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic probe_done = 1'b0;
    logic probe_fail = 1'b0;
    logic probe_req;
    logic [5:0] clk_dly_code;
    logic [LANES*4-1:0] dqs_dly_code;
    logic train_ok, train_done;

    always #10 clk = ~clk;

    read_delay_trainer #(.LANES(LANES), .SETTLE_CYC(SETTLE)) u_read_delay_trainer (
        .clk(clk), .rst_n(rst_n), .start(start),
        .probe_done(probe_done), .probe_fail(probe_fail),
        .probe_req(probe_req), .clk_dly_code(clk_dly_code),
        .dqs_dly_code(dqs_dly_code), .train_ok(train_ok), .train_done(train_done)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int clk_tbl [15] = '{7, 6, 5, 4, 3, 2, 1, 0, 8, 16, 24, 32, 40, 48, 56};
    int dqs_tbl [7]  = '{3, 2, 1, 0, 14, 13, 12};

    logic [6:0] pmap [15];
    bit kill_strobe = 0;
    bit kill_final  = 0;
    int lat = 2;

    int probe_n = 0, seq_bad = 0, settle_bad = 0, lane_bad = 0, hs_bad = 0;
    int stab = 0;
    logic [5+LANES*4:0] codes_prev = '0;
    bit req_prev = 0, busy = 0;
    int wait_c = 0, cur_ci = 0, cur_di = 0;

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int find_clk(input int code);
        for (int i = 0; i < 15; i++) if (clk_tbl[i] == code) return i;
        return -1;
    endfunction

    function automatic int find_dqs(input int code);
        for (int i = 0; i < 7; i++) if (dqs_tbl[i] == code) return i;
        return -1;
    endfunction

    // probe model and port monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if ({clk_dly_code, dqs_dly_code} != codes_prev) stab = 0;
            else if (stab < 1000000) stab++;
            codes_prev = {clk_dly_code, dqs_dly_code};

            if (probe_done) begin
                probe_done = 0;
                busy = 0;
            end else if (busy) begin
                if (!probe_req) hs_bad++;
                if (wait_c == 0) begin
                    bit f;
                    f = (cur_ci < 0 || cur_di < 0) ? 1'b1 : !pmap[cur_ci][cur_di];
                    if (kill_strobe && probe_n > 105 && !(clk_dly_code == 0 && dqs_dly_code == 0)) f = 1;
                    if (kill_final && probe_n == 113) f = 1;
                    probe_fail = f;
                    probe_done = 1;
                end else begin
                    wait_c--;
                end
            end

            if (probe_req && !req_prev) begin
                probe_n++;
                if (stab < SETTLE) settle_bad++;
                for (int k = 1; k < LANES; k++)
                    if (dqs_dly_code[k*4 +: 4] != dqs_dly_code[3:0]) lane_bad++;
                cur_ci = find_clk(int'(clk_dly_code));
                cur_di = find_dqs(int'(dqs_dly_code[3:0]));
                if (probe_n <= 105 && (cur_ci != (probe_n - 1) / 7 || cur_di != (probe_n - 1) % 7))
                    seq_bad++;
                busy = 1;
                wait_c = lat;
            end
            req_prev = probe_req;
        end
    end

    function automatic int centre_b(input int lo, input int hi, input int n);
        int c;
        c = (lo + hi) / 2;
        if (hi == n - 1 && lo > 0) c = (n + c) / 2;
        else if (hi < n - 1 && lo == 0) c = c / 2;
        return c;
    endfunction

    task automatic run_and_check(input string name);
        int cnt [15];
        int t, lo, hi, ci, di, e_n, e_clk, e_dqs;
        bit e_ok, zero;
        logic [6:0] fl;
        probe_n = 0; seq_bad = 0; settle_bad = 0; lane_bad = 0; hs_bad = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        while (!train_done) @(negedge clk);

        // reference result from the requirements
        for (int i = 0; i < 15; i++) cnt[i] = $countones(pmap[i]);
        lo = -1; hi = -1;
        for (t = 7; t >= 1; t--) begin
            for (int i = 0; i < 15; i++)
                if (cnt[i] == t) begin if (lo < 0) lo = i; hi = i; end
            if (lo >= 0) break;
        end
        zero = 0; ci = 0; di = 0;
        if (lo < 0) begin
            zero = 1; e_n = 106;
        end else begin
            ci = centre_b(lo, hi, 15);
            if (cnt[ci] < t) ci = lo;
            fl = kill_strobe ? 7'd0 : pmap[ci];
            e_n = 113;
            if (fl == 0) zero = 1;
            else begin
                lo = -1; hi = -1;
                for (int i = 0; i < 7; i++) if (fl[i]) begin if (lo < 0) lo = i; hi = i; end
                di = centre_b(lo, hi, 7);
                if (!fl[di]) di = lo;
            end
        end
        if (zero) e_ok = pmap[7][3];
        else e_ok = pmap[ci][di] && !kill_final;
        e_clk = zero ? 0 : clk_tbl[ci];
        e_dqs = zero ? 0 : dqs_tbl[di];

        $display("scenario %s", name);
        chk("R2 probe count (R9/R10 totals)", probe_n == e_n, probe_n, e_n);
        chk("R2 sweep order", seq_bad == 0, seq_bad, 0);
        chk("R2 lanes equal", lane_bad == 0, lane_bad, 0);
        chk("R3 settle before request", settle_bad == 0, settle_bad, 0);
        chk("R4 request held until done", hs_bad == 0, hs_bad, 0);
        chk("R5/R6/R7 clock code", clk_dly_code == e_clk, clk_dly_code, e_clk);
        for (int k = 0; k < LANES; k++)
            chk("R8 strobe code", dqs_dly_code[k*4 +: 4] == e_dqs, dqs_dly_code[k*4 +: 4], e_dqs);
        chk("R8 status", train_ok == e_ok, train_ok, e_ok);
    endtask

    task automatic clear_map();
        for (int i = 0; i < 15; i++) pmap[i] = 7'd0;
        kill_strobe = 0; kill_final = 0;
    endtask

    task automatic t_reset();
        chk("R1 req after reset", probe_req == 0, probe_req, 0);
        chk("R1 done after reset", train_done == 0, train_done, 0);
        chk("R1 ok after reset", train_ok == 0, train_ok, 0);
        chk("R1 codes after reset", clk_dly_code == 0 && dqs_dly_code == 0,
            int'(clk_dly_code) + int'(dqs_dly_code), 0);
    endtask

    task automatic t_centred();   // R6 interior window
        clear_map();
        for (int i = 2; i <= 6; i++) pmap[i] = 7'b0001110;
        lat = 1;
        run_and_check("interior window");
    endtask

    task automatic t_high_edge(); // R6 window on the last clock index
        clear_map();
        for (int i = 10; i <= 14; i++) pmap[i] = 7'b1111000;
        lat = 3;
        run_and_check("high edge");
    endtask

    task automatic t_low_edge();  // R6 window on index 0, R11 hold and ignored start
        int held_clk;
        clear_map();
        for (int i = 0; i <= 5; i++) pmap[i] = 7'b0001111;
        lat = 0;
        fork
            run_and_check("low edge");
            begin
                repeat (3000) @(negedge clk);
                start = 1;
                @(negedge clk) start = 0;
            end
        join
        held_clk = clk_dly_code;
        repeat (20) @(negedge clk);
        chk("R11 done held", train_done == 1, train_done, 1);
        chk("R11 codes held", clk_dly_code == held_clk, clk_dly_code, held_clk);
    endtask

    task automatic t_split();     // R5/R7 split best window, weaker middle
        clear_map();
        pmap[1] = 7'b0011111;
        pmap[13] = 7'b1111100;
        pmap[7] = 7'b0000110;
        for (int i = 4; i <= 6; i++) pmap[i] = 7'b0000111;
        lat = 2;
        run_and_check("split window");
    endtask

    task automatic t_none();      // R9 nothing passes
        clear_map();
        lat = 1;
        run_and_check("no pass");
    endtask

    task automatic t_strobe_empty(); // R10 second pass all fail, zero probe passes
        clear_map();
        for (int i = 3; i <= 9; i++) pmap[i] = 7'b0111110;
        pmap[7][3] = 1'b1;
        kill_strobe = 1;
        lat = 2;
        run_and_check("empty strobe pass");
    endtask

    task automatic t_final_fail(); // R8 confirming probe fails
        clear_map();
        for (int i = 5; i <= 8; i++) pmap[i] = 7'b0011100;
        kill_final = 1;
        lat = 1;
        run_and_check("confirm fails");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_centred();
        t_high_edge();
        t_low_edge();
        t_split();
        t_none();
        t_strobe_empty();
        t_final_fail();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule